// File: doc/BRIEF.md
# Control/Status Register Access Unit

This unit carries out the six register-access instructions that read and modify control/status registers (CSRs) in a 32-bit core. Each cycle in which `instValid` is high, it takes one already-fetched instruction word and the value of its source register. It decodes the word and looks up the addressed CSR. It returns the previous contents of that CSR, modifies the CSR in place, and drives strobes for the read and the write.

The unit contains four example CSRs. Three of them are storage registers, each with its own mask of writable bits. The fourth is read-only and returns a constant.

The side effects of an access depend on which operands the instruction names, not on the values those operands hold:
- A swap whose destination is x0 performs no read.
- A set or clear whose source field is zero performs no write.
- A set or clear that names a real register holding zero still performs its write.

Any write attempt on the read-only CSR raises a one-cycle illegal flag, and so does any access to an address that is not implemented. In both cases no CSR changes.

Every response appears on registered outputs one clock after the instruction is presented. The old value is read and the new value is stored on the same edge, so two instructions issued back to back each see the result of the one before.

Top module: `csr_unit`

## Requirements
- R1: An instruction is accepted only when bits 6:0 equal 1110011 and bits 14:12 are one of the six codes 001 (swap), 010 (set), 011 (clear), 101 (swap immediate), 110 (set immediate) or 111 (clear immediate). Any other accepted-cycle word raises `illegal`. The remaining fields are: bits 11:7 give rd, bits 19:15 give the rs1 index or the immediate, and bits 31:20 give the CSR address.
- R2: All outputs respond exactly one clock after a cycle with `instValid` high. After a cycle with `instValid` low, `csrReadEn`, `csrWriteEn`, `rdWriteEn` and `illegal` are all low.
- R3: When a read is performed, `rdValue` carries the old CSR value, zero-extended to 32 bits; otherwise `rdValue` is zero. `rdWriteEn` is high for a legal instruction whose rd is not x0.
- R4: A swap stores the source value, but only into bits marked writable; all other bits keep their value. `csrWriteData` shows the stored result. The writable masks are 0x0000188A at address 0x300, 0xFFFFFFFC at 0x305 and 0xFFFFFFFF at 0x340.
- R5: A set form ORs the source mask into the writable bits of the CSR.
- R6: A clear form clears every writable bit that is high in the source mask.
- R7: The three immediate forms use bits 19:15 as an unsigned value, zero-extended to 32 bits, in place of the register value.
- R8: For a swap or swap-immediate whose rd is x0, `csrReadEn` stays low while the write still happens. Every other legal form asserts `csrReadEn`.
- R9: A set or clear whose rs1 field is x0, and a set-immediate or clear-immediate whose immediate is 0, keep `csrWriteEn` low. These cases do not raise `illegal`, even on the read-only CSR at address 0xF11.
- R10: A set or clear whose rs1 names a register other than x0 asserts `csrWriteEn` even when that register holds zero. On the read-only CSR the same instruction raises `illegal`.
- R11: A write attempt on the read-only CSR, or any access to an unimplemented address, raises `illegal` for one cycle. In that case the read and write strobes and `rdWriteEn` stay low, `rdValue` is zero, and no CSR changes.
- R12: A synchronous active-high `rst` clears all storage CSRs and all outputs to zero.
- R13: Instructions presented in consecutive cycles are each applied atomically; the second one reads the value that the first one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Instruction word and source value are valid this cycle |
| instWord | input | 32 | Instruction word to execute |
| rs1Value | input | 32 | Contents of the register named by bits 19:15 |
| csrReadEn | output | 1 | Pulse: the addressed CSR was read |
| csrWriteEn | output | 1 | Pulse: the addressed CSR was written |
| csrAddr | output | 12 | Address of the CSR in the latest access |
| csrWriteData | output | 32 | Value stored by the write, zero when no write |
| rdValue | output | 32 | Old CSR value for the destination register |
| rdWriteEn | output | 1 | Pulse: rdValue should be written to rd |
| illegal | output | 1 | Pulse: illegal-instruction condition |

## Verification
The bench builds the unit with its default parameters. Under those defaults the read-only CSR returns 0x00000A5C. Because that constant is nonzero, a read that was performed can be told apart from a suppressed read that returns zero.

The three different writable masks let a single swap of all ones show, at the ports, which bits each CSR protects. The directed scenarios pair each operand-identity case with the read-only address: a zero immediate, the x0 source, and a real register holding zero. This separates gating by operand field from gating by operand value.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  localparam int XLEN      = 32;
  localparam int ADDR_W    = 12;
  localparam int REG_IDX_W = 5;
  localparam int CSR_COUNT = 4;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [XLEN-1:0]   mask;
    logic              readOnly;
  } csr_desc_t;

  typedef struct packed {
    logic              respond;
    logic              doRead;
    logic              doWrite;
    logic              illegal;
    logic              rdWe;
    csr_op_e           op;
    logic [XLEN-1:0]   operand;
    logic [ADDR_W-1:0] addr;
  } csr_strobe_t;

  function automatic csr_desc_t csrDesc(input int idx);
    csr_desc_t d;
    case (idx)
      0:       d = '{addr: 12'h300, mask: 32'h0000_188A, readOnly: 1'b0};
      1:       d = '{addr: 12'h305, mask: 32'hFFFF_FFFC, readOnly: 1'b0};
      2:       d = '{addr: 12'h340, mask: 32'hFFFF_FFFF, readOnly: 1'b0};
      default: d = '{addr: 12'hF11, mask: 32'h0000_0000, readOnly: 1'b1};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/csr_unit_ctrl.sv
module csr_unit_ctrl
  import csr_unit_pkg::*;
(
  input  logic                instValid,
  input  logic [XLEN-1:0]     instWord,
  input  logic [XLEN-1:0]     rs1Value,
  input  logic                addrHit,
  input  logic                addrReadOnly,
  output logic [ADDR_W-1:0]   lookupAddr,
  output csr_strobe_t         strobe
);
  localparam int SRC_LO = 15;
  localparam int RD_LO  = 7;

  logic [6:0]           opcode;
  logic [2:0]           funct3;
  logic [REG_IDX_W-1:0] rdIdx;
  logic [REG_IDX_W-1:0] srcField;
  logic                 opOk;
  logic                 isImm;
  logic                 isSwap;
  logic                 wantWrite;
  logic                 bad;
  csr_op_e              opKind;
  logic [XLEN-1:0]      srcVal;

  assign opcode     = instWord[6:0];
  assign rdIdx      = instWord[RD_LO +: REG_IDX_W];
  assign funct3     = instWord[14:12];
  assign srcField   = instWord[SRC_LO +: REG_IDX_W];
  assign lookupAddr = instWord[XLEN-1 -: ADDR_W];

  always_comb begin
    case (funct3[1:0])
      2'b01:   opKind = OP_WRITE;
      2'b10:   opKind = OP_SET;
      2'b11:   opKind = OP_CLEAR;
      default: opKind = OP_NONE;
    endcase
  end

  assign isImm  = funct3[2];
  assign isSwap = (opKind == OP_WRITE);
  assign opOk   = (opcode == OPC_SYSTEM) && (opKind != OP_NONE);
  assign srcVal = isImm ? {{(XLEN-REG_IDX_W){1'b0}}, srcField} : rs1Value;

  // Write intent depends on the operand field, never on the operand value.
  assign wantWrite = isSwap || (srcField != '0);

  assign bad = !opOk || !addrHit || (wantWrite && addrReadOnly);

  always_comb begin
    strobe         = '0;
    strobe.respond = instValid;
    strobe.addr    = lookupAddr;
    strobe.op      = opKind;
    strobe.operand = srcVal;
    if (instValid) begin
      strobe.illegal = bad;
      strobe.doWrite = !bad && wantWrite;
      strobe.doRead  = !bad && (!isSwap || (rdIdx != '0));
      strobe.rdWe    = !bad && (rdIdx != '0);
    end
  end
endmodule

// File: rtl/csr_unit_datapath.sv
module csr_unit_datapath
  import csr_unit_pkg::*;
#(
  parameter logic [XLEN-1:0] RO_VALUE = 32'h0000_0A5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  csr_strobe_t       strobe,
  output logic              addrHit,
  output logic              addrReadOnly,
  output logic              csrReadEn,
  output logic              csrWriteEn,
  output logic [ADDR_W-1:0] csrAddr,
  output logic [XLEN-1:0]   csrWriteData,
  output logic [XLEN-1:0]   rdValue,
  output logic              rdWriteEn,
  output logic              illegal
);
  logic [CSR_COUNT-1:0] hitVec;
  logic [XLEN-1:0]      valVec [CSR_COUNT];
  logic [XLEN-1:0]      oldValue;
  logic [XLEN-1:0]      hitMask;
  logic [XLEN-1:0]      candidate;
  logic [XLEN-1:0]      newValue;

  for (genvar g = 0; g < CSR_COUNT; g++) begin : g_csr
    localparam csr_desc_t DESC = csrDesc(g);
    assign hitVec[g] = (lookupAddr == DESC.addr);
    if (DESC.readOnly) begin : g_ro
      assign valVec[g] = RO_VALUE;
    end else begin : g_rw
      logic [XLEN-1:0] store;
      always_ff @(posedge clk) begin
        if (rst) begin
          store <= '0;
        end else if (strobe.doWrite && hitVec[g]) begin
          store <= newValue;
        end
      end
      assign valVec[g] = store;
    end
  end

  always_comb begin
    oldValue     = '0;
    hitMask      = '0;
    addrReadOnly = 1'b0;
    for (int i = 0; i < CSR_COUNT; i++) begin
      if (hitVec[i]) begin
        oldValue     = oldValue | valVec[i];
        hitMask      = hitMask | csrDesc(i).mask;
        addrReadOnly = addrReadOnly | csrDesc(i).readOnly;
      end
    end
  end

  assign addrHit = |hitVec;

  always_comb begin
    case (strobe.op)
      OP_WRITE: candidate = strobe.operand;
      OP_SET:   candidate = oldValue | strobe.operand;
      OP_CLEAR: candidate = oldValue & ~strobe.operand;
      default:  candidate = oldValue;
    endcase
  end

  assign newValue = (oldValue & ~hitMask) | (candidate & hitMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      csrReadEn    <= 1'b0;
      csrWriteEn   <= 1'b0;
      csrAddr      <= '0;
      csrWriteData <= '0;
      rdValue      <= '0;
      rdWriteEn    <= 1'b0;
      illegal      <= 1'b0;
    end else begin
      csrReadEn    <= strobe.doRead;
      csrWriteEn   <= strobe.doWrite;
      rdWriteEn    <= strobe.rdWe;
      illegal      <= strobe.illegal;
      csrWriteData <= strobe.doWrite ? newValue : '0;
      rdValue      <= strobe.doRead ? oldValue : '0;
      if (strobe.respond) begin
        csrAddr <= strobe.addr;
      end
    end
  end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_unit_pkg::*;
#(
  parameter logic [31:0] RO_VALUE = 32'h0000_0A5C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  input  logic [31:0] instWord,
  input  logic [31:0] rs1Value,
  output logic        csrReadEn,
  output logic        csrWriteEn,
  output logic [11:0] csrAddr,
  output logic [31:0] csrWriteData,
  output logic [31:0] rdValue,
  output logic        rdWriteEn,
  output logic        illegal
);
  csr_strobe_t       strobe;
  logic [ADDR_W-1:0] lookupAddr;
  logic              addrHit;
  logic              addrReadOnly;

  csr_unit_ctrl u_ctrl (
    .instValid    (instValid),
    .instWord     (instWord),
    .rs1Value     (rs1Value),
    .addrHit      (addrHit),
    .addrReadOnly (addrReadOnly),
    .lookupAddr   (lookupAddr),
    .strobe       (strobe)
  );

  csr_unit_datapath #(.RO_VALUE(RO_VALUE)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .lookupAddr   (lookupAddr),
    .strobe       (strobe),
    .addrHit      (addrHit),
    .addrReadOnly (addrReadOnly),
    .csrReadEn    (csrReadEn),
    .csrWriteEn   (csrWriteEn),
    .csrAddr      (csrAddr),
    .csrWriteData (csrWriteData),
    .rdValue      (rdValue),
    .rdWriteEn    (rdWriteEn),
    .illegal      (illegal)
  );
endmodule

// File: rtl/csr_unit_checker.sv
module csr_unit_checker
  import csr_unit_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic        csrReadEn,
  input logic        csrWriteEn,
  input logic [11:0] csrAddr,
  input logic [31:0] csrWriteData,
  input logic [31:0] rdValue,
  input logic        rdWriteEn,
  input logic        illegal
);
  function automatic logic [31:0] maskOf(input logic [11:0] a);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < CSR_COUNT; i++) begin
      if (csrDesc(i).addr == a) m = csrDesc(i).mask;
    end
    return m;
  endfunction

  function automatic logic isReadOnly(input logic [11:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < CSR_COUNT; i++) begin
      if (csrDesc(i).addr == a && csrDesc(i).readOnly) r = 1'b1;
    end
    return r;
  endfunction

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(instValid) |-> !(csrReadEn || csrWriteEn || rdWriteEn || illegal));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!csrReadEn && !csrWriteEn && !rdWriteEn && rdValue == '0));

  p_ro_unwritten_r11: assert property (@(posedge clk) disable iff (rst)
    csrWriteEn |-> !isReadOnly(csrAddr));

  p_write_masked_r4: assert property (@(posedge clk) disable iff (rst)
    csrWriteEn |-> ((csrWriteData & ~maskOf(csrAddr)) == '0));

  p_rd_not_x0_r3: assert property (@(posedge clk) disable iff (rst)
    rdWriteEn |-> ($past(instWord[11:7]) != 5'd0));

  p_swap_x0_noread_r8: assert property (@(posedge clk) disable iff (rst)
    $past(instValid && instWord[13:12] == 2'b01 && instWord[11:7] == 5'd0) |-> !csrReadEn);

  p_zero_src_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    $past(instValid && instWord[13] && instWord[19:15] == 5'd0) |-> !csrWriteEn);
endmodule

bind csr_unit csr_unit_checker u_checker (
  .clk          (clk),
  .rst          (rst),
  .instValid    (instValid),
  .instWord     (instWord),
  .csrReadEn    (csrReadEn),
  .csrWriteEn   (csrWriteEn),
  .csrAddr      (csrAddr),
  .csrWriteData (csrWriteData),
  .rdValue      (rdValue),
  .rdWriteEn    (rdWriteEn),
  .illegal      (illegal)
);

// File: tb/csr_unit_bench.sv
module csr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RO_VAL = 32'h0000_0A5C;
  localparam logic [2:0] F_RW = 3'b001, F_RS = 3'b010, F_RC = 3'b011;
  localparam logic [2:0] F_RWI = 3'b101, F_RSI = 3'b110, F_RCI = 3'b111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] rs1Value = '0;
  logic        csrReadEn, csrWriteEn, rdWriteEn, illegal;
  logic [11:0] csrAddr;
  logic [31:0] csrWriteData, rdValue;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_unit u_csr_unit (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .rs1Value(rs1Value), .csrReadEn(csrReadEn), .csrWriteEn(csrWriteEn),
    .csrAddr(csrAddr), .csrWriteData(csrWriteData), .rdValue(rdValue),
    .rdWriteEn(rdWriteEn), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [4:0] src, input logic [11:0] addr);
    return {addr, src, f3, rd, 7'b1110011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one instruction for one cycle; on return its response is visible.
  task automatic issue(input logic [31:0] w, input logic [31:0] v);
    @(negedge clk);
    instWord  = w;
    rs1Value  = v;
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic chkStrobes(input string tag, input logic re, input logic we,
                            input logic rwe, input logic ill);
    chk({tag, " readEn"}, {31'd0, csrReadEn}, {31'd0, re});
    chk({tag, " writeEn"}, {31'd0, csrWriteEn}, {31'd0, we});
    chk({tag, " rdWriteEn"}, {31'd0, rdWriteEn}, {31'd0, rwe});
    chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, ill});
  endtask

  task automatic readCsr(input string tag, input logic [11:0] a, input logic [31:0] exp);
    issue(mk(F_RS, 5'd1, 5'd0, a), 32'hFFFF_FFFF);
    chk({tag, " readback"}, rdValue, exp);
    chk({tag, " readback no write"}, {31'd0, csrWriteEn}, 32'd0);
  endtask

  task automatic t_reset;
    chkStrobes("R12 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 reset rdValue", rdValue, 32'd0);
    readCsr("R12 reset 340", 12'h340, 32'd0);
    readCsr("R12 reset 300", 12'h300, 32'd0);
  endtask

  task automatic t_swap;
    issue(mk(F_RW, 5'd5, 5'd3, 12'h340), 32'hDEAD_BEEF);
    chkStrobes("R4 swap", 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R4 swap data", csrWriteData, 32'hDEAD_BEEF);
    chk("R3 swap old", rdValue, 32'd0);
    chk("R4 swap addr", {20'd0, csrAddr}, 32'h340);
    issue(mk(F_RW, 5'd5, 5'd3, 12'h340), 32'h1234_5678);
    chk("R3 swap returns old", rdValue, 32'hDEAD_BEEF);
    issue(mk(F_RW, 5'd2, 5'd3, 12'h305), 32'hFFFF_FFFF);
    chk("R4 mask 305", csrWriteData, 32'hFFFF_FFFC);
    readCsr("R4 mask 305", 12'h305, 32'hFFFF_FFFC);
  endtask

  task automatic t_setclear;
    issue(mk(F_RS, 5'd6, 5'd3, 12'h300), 32'h0000_FFFF);
    chkStrobes("R5 set", 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5 set data", csrWriteData, 32'h0000_188A);
    issue(mk(F_RC, 5'd6, 5'd3, 12'h300), 32'h0000_0008);
    chk("R6 clear old", rdValue, 32'h0000_188A);
    chk("R6 clear data", csrWriteData, 32'h0000_1882);
    readCsr("R6 clear", 12'h300, 32'h0000_1882);
  endtask

  task automatic t_imm;
    issue(mk(F_RWI, 5'd1, 5'd31, 12'h340), 32'hFFFF_FFFF);
    chk("R7 swap imm data", csrWriteData, 32'h0000_001F);
    issue(mk(F_RCI, 5'd1, 5'd3, 12'h340), 32'hFFFF_FFFF);
    chk("R7 clear imm data", csrWriteData, 32'h0000_001C);
    issue(mk(F_RSI, 5'd1, 5'd0, 12'h340), 32'hFFFF_FFFF);
    chkStrobes("R9 set imm zero", 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 set imm zero old", rdValue, 32'h0000_001C);
    issue(mk(F_RSI, 5'd1, 5'd16, 12'h340), 32'd0);
    chk("R7 set imm data", csrWriteData, 32'h0000_001C | 32'h10);
  endtask

  task automatic t_swap_x0;
    issue(mk(F_RW, 5'd0, 5'd9, 12'h340), 32'hCAFE_0001);
    chkStrobes("R8 swap rd x0", 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 swap rd x0 rdValue", rdValue, 32'd0);
    issue(mk(F_RWI, 5'd0, 5'd4, 12'h340), 32'd0);
    chkStrobes("R8 swapimm rd x0", 1'b0, 1'b1, 1'b0, 1'b0);
    readCsr("R8 swapimm rd x0", 12'h340, 32'h0000_0004);
  endtask

  task automatic t_ro_gate;
    issue(mk(F_RS, 5'd2, 5'd0, 12'hF11), 32'hFFFF_FFFF);
    chkStrobes("R9 set x0 on ro", 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 set x0 on ro value", rdValue, RO_VAL);
    issue(mk(F_RCI, 5'd2, 5'd0, 12'hF11), 32'hFFFF_FFFF);
    chkStrobes("R9 clear imm zero on ro", 1'b1, 1'b0, 1'b1, 1'b0);
    issue(mk(F_RS, 5'd2, 5'd4, 12'h340), 32'd0);
    chkStrobes("R10 set zero reg", 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R10 set zero reg data", csrWriteData, 32'h0000_0004);
    issue(mk(F_RC, 5'd2, 5'd4, 12'hF11), 32'd0);
    chkStrobes("R10 clear zero reg on ro", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_illegal;
    issue(mk(F_RW, 5'd2, 5'd3, 12'hF11), 32'hFFFF_FFFF);
    chkStrobes("R11 swap on ro", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 swap on ro rdValue", rdValue, 32'd0);
    readCsr("R11 ro unchanged", 12'hF11, RO_VAL);
    issue(mk(F_RS, 5'd2, 5'd0, 12'h123), 32'd0);
    chkStrobes("R11 unimplemented", 1'b0, 1'b0, 1'b0, 1'b1);
    issue(mk(F_RW, 5'd2, 5'd3, 12'h456), 32'h55);
    chkStrobes("R11 unimplemented write", 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chkStrobes("R11 illegal one cycle", 1'b0, 1'b0, 1'b0, 1'b0);
    issue(mk(3'b100, 5'd2, 5'd3, 12'h340), 32'h77);
    chkStrobes("R1 funct3 100", 1'b0, 1'b0, 1'b0, 1'b1);
    issue(mk(3'b000, 5'd2, 5'd3, 12'h340), 32'h77);
    chkStrobes("R1 funct3 000", 1'b0, 1'b0, 1'b0, 1'b1);
    issue(mk(F_RW, 5'd2, 5'd3, 12'h340) ^ 32'h0000_0040, 32'h77);
    chkStrobes("R1 bad opcode", 1'b0, 1'b0, 1'b0, 1'b1);
    readCsr("R11 340 unchanged", 12'h340, 32'h0000_0004);
  endtask

  task automatic t_idle;
    @(negedge clk);
    instWord = mk(F_RW, 5'd1, 5'd1, 12'h340);
    rs1Value = 32'hFFFF_FFFF;
    @(negedge clk);
    chkStrobes("R2 idle", 1'b0, 1'b0, 1'b0, 1'b0);
    readCsr("R2 idle no effect", 12'h340, 32'h0000_0004);
  endtask

  task automatic t_back2back;
    @(negedge clk);
    instWord = mk(F_RW, 5'd1, 5'd3, 12'h340); rs1Value = 32'h0000_00F0; instValid = 1'b1;
    @(negedge clk);
    chk("R13 first old", rdValue, 32'h0000_0004);
    instWord = mk(F_RS, 5'd1, 5'd3, 12'h340); rs1Value = 32'h0000_000F;
    @(negedge clk);
    chk("R13 second sees first", rdValue, 32'h0000_00F0);
    chk("R13 second data", csrWriteData, 32'h0000_00FF);
    instWord = mk(F_RC, 5'd1, 5'd3, 12'h340); rs1Value = 32'h0000_0011;
    @(negedge clk);
    instValid = 1'b0;
    chk("R13 third sees second", rdValue, 32'h0000_00FF);
    chk("R13 third data", csrWriteData, 32'h0000_00EE);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    readCsr("R12 mid reset 340", 12'h340, 32'd0);
    readCsr("R12 mid reset 305", 12'h305, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_swap();
    t_setclear();
    t_imm();
    t_swap_x0();
    t_ro_gate();
    t_illegal();
    t_idle();
    t_back2back();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule